// File: doc/BRIEF.md
# Key-Protected Nonvolatile Memory Command Controller

This block sits between a CPU register bus and a nonvolatile memory array. Software uses four small registers to start an erase or a program cycle. It sets a control register with an operation code, an erase flag, a write-enable bit and a start bit. It writes a key register, a page register and an in-page offset register. The array side gets a held request, a target address and an erase/program selector. The array ends the cycle with a one-cycle done pulse.

A start is accepted only after an unlock. The key register must first take 8'h55 and then 8'hAA as two consecutive bus writes, and the write-enable bit must be set in the same control write that sets the start bit. A rejected start sets a sticky error flag. While a cycle runs, the CPU stall output stays high and every register write is dropped. The start bit clears by itself once the array reports completion.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Register offsets on `bus_addr` are 0 control, 1 key, 2 page, 3 offset. Control read layout: bit 15 start, bit 14 erase flag, bit 13 sticky error, bit 6 write-enable, bits [3:0] operation code, all other bits 0. The key register reads 0. After reset the control register reads 0, stall and the array request are low, and the unlock is cleared.
- R2: A key write of 8'h55 followed by a key write of 8'hAA, with no other bus write between them, unlocks the block. A following control write with bit 15 and bit 6 set and a supported operation code starts a cycle. Stall and the array request go high in the cycle after that write.
- R3: A key pair in the wrong order, a wrong key value, or any other bus write between the two keys leaves the block locked. A start attempted while locked does not begin and sets the error bit.
- R4: A control write with bit 15 set and bit 6 clear starts nothing and sets the error bit.
- R5: Only operation codes 4'b0010 (block erase) and 4'b0001 (row program) are supported. Bit 15 with any other code starts nothing and sets the error bit.
- R6: The unlock is used up by the next control write of any value, so a later start needs a fresh key pair.
- R7: For code 4'b0010, `arr_erase` is 1 and `arr_addr` is the target aligned down to a 512-word block (8 rows of 64 words).
- R8: For code 4'b0001, `arr_erase` is 0 and `arr_addr` is the target aligned down to a 64-word row.
- R9: Stall and the start bit stay set until `arr_done` is sampled high. Both are clear in the next cycle with no CPU write. A done pulse while idle has no effect.
- R10: While a cycle runs, writes to the control, key, page and offset registers are ignored.
- R11: The error bit stays set until reset, including across later successful cycles.
- R12: The target address is the page register in the upper bits joined with the 16-bit offset in the lower bits, captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| cpu_stall | output | 1 | High while a cycle runs |
| arr_req | output | 1 | Command request to the array, held for the cycle |
| arr_erase | output | 1 | 1 block erase, 0 row program |
| arr_addr | output | 24 | Aligned target address |
| arr_done | input | 1 | Completion pulse from the array |

## Verification
The bench builds the block with its default parameters: an 8-bit page, a 16-bit offset, 64-word rows and 8 rows per erase block, which gives a 24-bit array address. These values let an offset such as 16'hABCD expose both alignment masks in one run: the low 6 bits clear for a row and the low 9 bits clear for a block. The upper page byte shows that the page sits above the offset. Every rejection path is driven from a fresh reset, so the error bit seen in each case comes from that case alone.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int CSR_W = 16;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_KEY  = 2'd1;
    localparam logic [1:0] REG_PAGE = 2'd2;
    localparam logic [1:0] REG_OFFS = 2'd3;

    localparam int BIT_START = 15;
    localparam int BIT_ERASE = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_WREN  = 6;

    localparam logic [3:0] OPC_ROW   = 4'b0001;
    localparam logic [3:0] OPC_BLOCK = 4'b0010;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HALF  = 2'd1,
        LK_OPEN  = 2'd2
    } lock_state_e;
endpackage

// File: rtl/flash_unlock.sv
module flash_unlock
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic       is_key,
    input  logic       is_ctrl,
    input  logic [7:0] key_val,
    output logic       unlocked
);
    lock_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            if (is_key && key_val == KEY_FIRST)
                st_d = LK_HALF;
            else if (is_key && key_val == KEY_SECOND && st_q == LK_HALF)
                st_d = LK_OPEN;
            else if (st_q == LK_OPEN && !is_key && !is_ctrl)
                st_d = LK_OPEN;
            else
                st_d = LK_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_IDLE;
        else        st_q <= st_d;
    end

    assign unlocked = (st_q == LK_OPEN);

    // R2: an unlock only appears right after the second key
    assert_unlock_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_ok && is_key && key_val == KEY_SECOND));

    // R6: a control write always uses up the unlock
    assert_ctrl_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && is_ctrl) |=> !unlocked);
endmodule

// File: rtl/flash_addr_align.sv
module flash_addr_align #(
    parameter int ADDR_W = 24,
    parameter int ROW_LG = 6,
    parameter int BLK_LG = 9
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              blk_mode,
    output logic [ADDR_W-1:0] addr_out
);
    logic unused_low;
    assign unused_low = ^addr_in[ROW_LG-1:0];

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < ROW_LG) begin : g_row
            assign addr_out[i] = 1'b0;
        end else if (i < BLK_LG) begin : g_blk
            assign addr_out[i] = addr_in[i] & ~blk_mode;
        end else begin : g_keep
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int PAGE_W       = 8,
    parameter int OFF_W        = 16,
    parameter int ROW_WORDS    = 64,
    parameter int ROWS_PER_BLK = 8,
    localparam int ADDR_W      = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    output logic              cpu_stall,
    output logic              arr_req,
    output logic              arr_erase,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic              arr_done
);
    localparam int ROW_LG = $clog2(ROW_WORDS);
    localparam int BLK_LG = $clog2(ROW_WORDS * ROWS_PER_BLK);

    typedef struct packed {
        logic              wr;
        logic              erase;
        logic              err;
        logic              wren;
        logic [3:0]        op;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  offs;
        logic              arr_blk;
        logic [ADDR_W-1:0] arr_addr;
    } ctl_t;

    ctl_t s_d, s_q;
    logic busy, wr_ok, unlocked, op_ok, new_blk;
    logic [ADDR_W-1:0] aligned;
    logic unused_bits;

    assign unused_bits = ^bus_wdata;
    assign busy    = s_q.wr;
    assign wr_ok   = bus_wr && !busy;
    assign op_ok   = (bus_wdata[3:0] == OPC_ROW) || (bus_wdata[3:0] == OPC_BLOCK);
    assign new_blk = (bus_wdata[3:0] == OPC_BLOCK);

    flash_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .is_key   (bus_addr == REG_KEY),
        .is_ctrl  (bus_addr == REG_CTRL),
        .key_val  (bus_wdata[7:0]),
        .unlocked (unlocked)
    );

    flash_addr_align #(
        .ADDR_W (ADDR_W),
        .ROW_LG (ROW_LG),
        .BLK_LG (BLK_LG)
    ) u_align (
        .addr_in  ({s_q.page, s_q.offs}),
        .blk_mode (new_blk),
        .addr_out (aligned)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ok) begin
            case (bus_addr)
                REG_CTRL: begin
                    s_d.op    = bus_wdata[3:0];
                    s_d.wren  = bus_wdata[BIT_WREN];
                    s_d.erase = bus_wdata[BIT_ERASE];
                    if (bus_wdata[BIT_START]) begin
                        if (unlocked && bus_wdata[BIT_WREN] && op_ok) begin
                            s_d.wr       = 1'b1;
                            s_d.arr_blk  = new_blk;
                            s_d.arr_addr = aligned;
                        end else begin
                            s_d.err = 1'b1;
                        end
                    end
                end
                REG_PAGE: s_d.page = PAGE_W'(bus_wdata);
                REG_OFFS: s_d.offs = OFF_W'(bus_wdata);
                default: ;
            endcase
        end
        if (busy && arr_done) s_d.wr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {s_q.wr, s_q.erase, s_q.err, 6'b0, s_q.wren, 2'b0, s_q.op};
            REG_PAGE: bus_rdata = CSR_W'(s_q.page);
            REG_OFFS: bus_rdata = CSR_W'(s_q.offs);
            default:  bus_rdata = '0;
        endcase
    end

    assign cpu_stall = s_q.wr;
    assign arr_req   = s_q.wr;
    assign arr_erase = s_q.arr_blk;
    assign arr_addr  = s_q.arr_addr;

    // R2: a cycle begins only from a control write carrying start and write-enable
    assert_start_from_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(bus_wr && bus_addr == REG_CTRL
                                   && bus_wdata[BIT_START] && bus_wdata[BIT_WREN]));

    // R9: stall holds until done, then drops
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && !arr_done) |=> cpu_stall);
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && arr_done) |=> !cpu_stall);

    // R10: the target registers are frozen during a cycle
    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> ($stable(s_q.page) && $stable(s_q.offs) && $stable(arr_addr)));

    // R11: the error flag never clears outside reset
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);

    // R7: a block erase target is aligned to the erase block
    assert_block_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_erase) |-> (arr_addr[BLK_LG-1:0] == '0));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cpu_stall, arr_req, arr_erase;
    logic [23:0] arr_addr;
    logic        arr_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_ctrl u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall),
        .arr_req(arr_req), .arr_erase(arr_erase), .arr_addr(arr_addr),
        .arr_done(arr_done)
    );

    typedef struct packed {
        logic [7:0]  k1;
        logic [7:0]  k2;
        logic [15:0] ctrl;
        logic        go;
        logic        err;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h55, 8'hAA, 16'hC042, 1'b1, 1'b0, 4'd2},  // R2 block erase start
        '{8'h55, 8'hAA, 16'h8041, 1'b1, 1'b0, 4'd2},  // R2 row program start
        '{8'hAA, 8'h55, 16'hC042, 1'b0, 1'b1, 4'd3},  // R3 swapped keys
        '{8'h55, 8'h56, 16'hC042, 1'b0, 1'b1, 4'd3},  // R3 wrong second key
        '{8'h55, 8'hAA, 16'hC002, 1'b0, 1'b1, 4'd4},  // R4 write-enable clear
        '{8'h55, 8'hAA, 16'h8043, 1'b0, 1'b1, 4'd5},  // R5 code 0011
        '{8'h55, 8'hAA, 16'h8040, 1'b0, 1'b1, 4'd5},  // R5 code 0000
        '{8'h55, 8'hAA, 16'h0042, 1'b0, 1'b0, 4'd2}   // R2 no start bit
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        arr_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        arr_done = 1'b1;
        @(posedge clk);
        #1 arr_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        do_reset();
        // R1 reset state
        rd(2'd0, r);
        chk("R1 ctrl", r, 16'h0000);
        chk("R1 stall", cpu_stall, 1'b0);
        chk("R1 req", arr_req, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd1, {8'h00, VECS[i].k1});
            wr(2'd1, {8'h00, VECS[i].k2});
            wr(2'd0, VECS[i].ctrl);
            @(negedge clk);
            chk($sformatf("R%0d vec %0d stall", VECS[i].tag, i), cpu_stall, VECS[i].go);
            rd(2'd0, r);
            chk($sformatf("R%0d vec %0d err", VECS[i].tag, i), r[13], VECS[i].err);
            if (VECS[i].go) pulse_done();
        end

        // R3 intervening page write between keys
        do_reset();
        wr(2'd1, 16'h0055);
        wr(2'd2, 16'h0001);
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'hC042);
        @(negedge clk);
        chk("R3 intervening stall", cpu_stall, 1'b0);
        rd(2'd0, r);
        chk("R3 intervening err", r[13], 1'b1);

        // R6 unlock used up by a plain control write
        do_reset();
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'h0042);
        wr(2'd0, 16'hC042);
        @(negedge clk);
        chk("R6 stall", cpu_stall, 1'b0);
        rd(2'd0, r);
        chk("R6 err", r[13], 1'b1);

        // R7 R12 block erase alignment, R9 R10 busy behaviour
        do_reset();
        wr(2'd2, 16'h0003);
        wr(2'd3, 16'hABCD);
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'hC042);
        @(negedge clk);
        chk("R7 erase sel", arr_erase, 1'b1);
        chk("R7 R12 addr", arr_addr, 24'h03AA00);
        chk("R9 req", arr_req, 1'b1);
        wr(2'd2, 16'h0077);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0055);
        @(negedge clk);
        chk("R9 stall held", cpu_stall, 1'b1);
        rd(2'd0, r);
        chk("R9 R10 ctrl busy", r, 16'hC042);
        rd(2'd2, r);
        chk("R10 page kept", r, 16'h0003);
        pulse_done();
        @(negedge clk);
        chk("R9 stall clear", cpu_stall, 1'b0);
        rd(2'd0, r);
        chk("R9 start bit clear", r[15], 1'b0);
        chk("R10 no half key", r[13], 1'b0);
        // the key write during the cycle must not count: a lone AA then start fails
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'h8041);
        @(negedge clk);
        chk("R10 key ignored", cpu_stall, 1'b0);

        // R8 row program alignment, R11 sticky error
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'h8041);
        @(negedge clk);
        chk("R8 erase sel", arr_erase, 1'b0);
        chk("R8 R12 addr", arr_addr, 24'h03ABC0);
        pulse_done();
        rd(2'd0, r);
        chk("R11 err kept", r[13], 1'b1);

        // R9 done while idle has no effect
        pulse_done();
        @(negedge clk);
        chk("R9 idle done", cpu_stall, 1'b0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule